// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects a parameterized number of peripheral interrupt lines, up to 32, and turns them into a single request line to a processor. Each line is conditioned at build time. It can be edge sensitive, reacting to either a rising or a falling edge, or level sensitive, either active high or active low. Edge-sensitive lines pass through a synchronizer first, so pulses that arrive asynchronously are captured safely. A captured edge stays latched until software acknowledges it. A level-sensitive line simply reflects its conditioned input.

Software uses a small 32-bit register port. The port has a word address, a write enable, write data and a combinational read path. Through it, software reads the raw status, the enabled (pending) status and the index of the most urgent pending line. It also sets the per-line enables, acknowledges captured edges and controls a master gate on the output.

The output is chosen at build time. It is either a level that follows "anything pending while the master gate is open", or a one-cycle pulse each time that condition turns on. Either form can be built with either polarity.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, status, pending and enable read zero, the master bit reads zero, the vector reads 0xFFFFFFFF, and irqOut sits at its inactive level (the inverse of OUT_POL).
- R2: An edge-sensitive line (EDGE_MASK bit 1) reacts to a rising edge when its POL_MASK bit is 1 and to a falling edge when the bit is 0. The active edge sets its status bit, which is visible on a read at the third rising clock edge after the input change. The bit then stays set until it is acknowledged.
- R3: Writing to address 3 (acknowledge) clears, at the next clock edge, each latched edge status bit whose data bit is 1. Bits written as 0 are untouched. If a new edge is captured in the same cycle as the acknowledge, the bit stays set. Address 3 reads zero.
- R4: A level-sensitive line (EDGE_MASK bit 0) has a status bit equal to its input when POL_MASK is 1, and to the inverted input when POL_MASK is 0, with no clock delay. An acknowledge has no effect on it.
- R5: Address 2 (enable) is read/write over NUM_IN bits. Address 1 (pending) reads status AND enable.
- R6: Address 5 (vector) reads the index of the lowest-numbered pending bit, where bit 0 has the highest priority. It reads 0xFFFFFFFF when nothing is pending.
- R7: Address 4, bit 0, is the master gate. In level output mode, irqOut equals OUT_POL exactly one clock after the cycle in which any pending bit is set and the master gate is 1. Otherwise it is inactive. With the gate clear, irqOut is always inactive.
- R8: In pulse output mode (OUT_LEVEL = 0), irqOut takes the OUT_POL level for exactly one cycle, one clock after the gated pending condition goes from 0 to 1. It is inactive at all other times.
- R9: Writes to addresses 0, 1, 5, 6 and 7 change nothing. Addresses 6 and 7 read zero.
- R10: Register bits at and above NUM_IN, and master bits above bit 0, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_IN | Peripheral interrupt lines |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data for addr |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The critical collision is an acknowledge that lands in the same cycle as a fresh capture of the same edge line. A second active edge is timed so that its detection meets the acknowledge write at one clock edge. The bit must still read as set afterwards, and a later acknowledge must clear it. Random traffic also writes acknowledges, enables and master changes while the input lines toggle. Every read and every output cycle is compared against a cycle model in the bench, which is built from the requirements, for both output modes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADR_STATUS  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PENDING = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_ENABLE  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_ACK     = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_MASTER  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_VECTOR  = 3'd5;

  localparam logic [DATA_W-1:0] VEC_NONE = '1;

  typedef struct packed {
    logic enableWrite;
    logic ackWrite;
    logic masterWrite;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_ctrl_ctl.sv
module irq_ctrl_ctl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_IN = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_IN-1:0] statusVec,
  input  logic [NUM_IN-1:0] pendingVec,
  input  logic [NUM_IN-1:0] enableReg,
  input  logic              masterEn,
  input  logic [DATA_W-1:0] vectorIdx,
  output ctlStrobe_t        strobes,
  output logic [DATA_W-1:0] rdData
);
  always_comb begin
    strobes.enableWrite = wrEn && (addr == ADR_ENABLE);
    strobes.ackWrite    = wrEn && (addr == ADR_ACK);
    strobes.masterWrite = wrEn && (addr == ADR_MASTER);
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADR_STATUS:  rdData[NUM_IN-1:0] = statusVec;
      ADR_PENDING: rdData[NUM_IN-1:0] = pendingVec;
      ADR_ENABLE:  rdData[NUM_IN-1:0] = enableReg;
      ADR_MASTER:  rdData[0] = masterEn;
      ADR_VECTOR:  rdData = vectorIdx;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_dp.sv
module irq_ctrl_dp
  import irq_ctrl_pkg::*;
#(
  parameter int                NUM_IN      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NUM_IN-1:0] EDGE_MASK   = '0,
  parameter logic [NUM_IN-1:0] POL_MASK    = '1,
  parameter bit                OUT_LEVEL   = 1'b1,
  parameter bit                OUT_POL     = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic [NUM_IN-1:0] wrBits,
  input  ctlStrobe_t        strobes,
  output logic [NUM_IN-1:0] statusVec,
  output logic [NUM_IN-1:0] pendingVec,
  output logic [NUM_IN-1:0] enableReg,
  output logic              masterEn,
  output logic [DATA_W-1:0] vectorIdx,
  output logic              irqOut
);
  localparam logic IDLE_LVL = ~OUT_POL;

  // normalise polarity: a 1 on condIn is always the active sense
  logic [NUM_IN-1:0] condIn;
  assign condIn = irqIn ~^ POL_MASK;

  for (genvar i = 0; i < NUM_IN; i++) begin : gLine
    if (EDGE_MASK[i]) begin : gEdge
      logic [SYNC_STAGES-1:0] syncChain;
      logic                   prevSync;
      logic                   latched;
      logic                   edgeSeen;
      logic                   ackHit;
      assign edgeSeen = syncChain[SYNC_STAGES-1] & ~prevSync;
      assign ackHit   = strobes.ackWrite & wrBits[i];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncChain <= '0;
          prevSync  <= 1'b0;
          latched   <= 1'b0;
        end else begin
          syncChain <= {syncChain[SYNC_STAGES-2:0], condIn[i]};
          prevSync  <= syncChain[SYNC_STAGES-1];
          latched   <= edgeSeen | (latched & ~ackHit);
        end
      end
      assign statusVec[i] = latched;
    end else begin : gLevel
      assign statusVec[i] = condIn[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= '0;
      masterEn  <= 1'b0;
    end else begin
      if (strobes.enableWrite) enableReg <= wrBits;
      if (strobes.masterWrite) masterEn  <= wrBits[0];
    end
  end

  assign pendingVec = statusVec & enableReg;

  always_comb begin
    vectorIdx = VEC_NONE;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pendingVec[i]) vectorIdx = DATA_W'(i);
    end
  end

  logic reqActive;
  assign reqActive = (|pendingVec) & masterEn;

  if (OUT_LEVEL) begin : gOutLevel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqOut <= IDLE_LVL;
      else       irqOut <= reqActive ? OUT_POL : IDLE_LVL;
    end
  end else begin : gOutPulse
    logic activePrev;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        activePrev <= 1'b0;
        irqOut     <= IDLE_LVL;
      end else begin
        activePrev <= reqActive;
        irqOut     <= (reqActive & ~activePrev) ? OUT_POL : IDLE_LVL;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int                NUM_IN      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NUM_IN-1:0] EDGE_MASK   = 8'h0F,
  parameter logic [NUM_IN-1:0] POL_MASK    = 8'h35,
  parameter bit                OUT_LEVEL   = 1'b1,
  parameter bit                OUT_POL     = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_IN-1:0]    irqIn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut
);
  ctlStrobe_t        strobes;
  logic [NUM_IN-1:0] statusVec;
  logic [NUM_IN-1:0] pendingVec;
  logic [NUM_IN-1:0] enableReg;
  logic              masterEn;
  logic [DATA_W-1:0] vectorIdx;

  irq_ctrl_ctl #(.NUM_IN(NUM_IN)) ctl_i (
    .wrEn(wrEn), .addr(addr), .statusVec(statusVec), .pendingVec(pendingVec),
    .enableReg(enableReg), .masterEn(masterEn), .vectorIdx(vectorIdx),
    .strobes(strobes), .rdData(rdData)
  );

  irq_ctrl_dp #(
    .NUM_IN(NUM_IN), .SYNC_STAGES(SYNC_STAGES), .EDGE_MASK(EDGE_MASK),
    .POL_MASK(POL_MASK), .OUT_LEVEL(OUT_LEVEL), .OUT_POL(OUT_POL)
  ) dp_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrBits(wrData[NUM_IN-1:0]),
    .strobes(strobes), .statusVec(statusVec), .pendingVec(pendingVec),
    .enableReg(enableReg), .masterEn(masterEn), .vectorIdx(vectorIdx),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker
  import irq_ctrl_pkg::*;
#(
  parameter int                NUM_IN    = 8,
  parameter logic [NUM_IN-1:0] EDGE_MASK = '0,
  parameter bit                OUT_LEVEL = 1'b1,
  parameter bit                OUT_POL   = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [NUM_IN-1:0] statusVec,
  input logic [NUM_IN-1:0] pendingVec,
  input logic              masterEn,
  input logic [DATA_W-1:0] vectorIdx,
  input logic              irqOut
);
  logic [NUM_IN-1:0] ackMaskNow;
  logic [NUM_IN-1:0] belowVec;
  logic              vecHit;

  assign ackMaskNow = (wrEn && addr == ADR_ACK) ? wrData[NUM_IN-1:0] : '0;

  always_comb begin
    vecHit = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      belowVec[i] = (DATA_W'(i) < vectorIdx);
      if (DATA_W'(i) == vectorIdx) vecHit = pendingVec[i];
    end
  end

  // R6: a reported vector points at a pending line with none more urgent
  assert_vec_lowest_R6: assert property (@(posedge clk) disable iff (!rstN)
    (vectorIdx != VEC_NONE) |-> (vecHit && ((pendingVec & belowVec) == '0)));

  assert_vec_none_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pendingVec == '0) |-> (vectorIdx == VEC_NONE));

  // R7: closed master gate keeps the request inactive next cycle
  assert_master_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |=> (irqOut == ~OUT_POL));

  // R2: a latched edge bit only drops after an acknowledge of that bit
  assert_edge_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((($past(statusVec) & EDGE_MASK) & ~$past(ackMaskNow)) & ~statusVec) == '0));

  if (!OUT_LEVEL) begin : gPulseChk
    // R8: the pulse lasts a single cycle
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
      (irqOut == OUT_POL) |=> (irqOut != OUT_POL));
  end
endmodule

bind irq_ctrl irq_ctrl_checker #(
  .NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK), .OUT_LEVEL(OUT_LEVEL), .OUT_POL(OUT_POL)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .statusVec(statusVec), .pendingVec(pendingVec), .masterEn(masterEn),
  .vectorIdx(vectorIdx), .irqOut(irqOut)
);

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
  localparam int        N    = 8;
  localparam logic [7:0] EDGE = 8'h0F;
  localparam logic [7:0] POL  = 8'h35;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  irqInT = ~POL;
  logic        wrEnT = 1'b0;
  logic [2:0]  addrT = 3'd0;
  logic [31:0] wrDataT = '0;
  logic [31:0] rdData, rdDataP;
  logic        irqOutL, irqOutP;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqInT), .wrEn(wrEnT), .addr(addrT),
    .wrData(wrDataT), .rdData(rdData), .irqOut(irqOutL)
  );

  irq_ctrl #(.OUT_LEVEL(1'b0), .OUT_POL(1'b0)) dutPulse_i (
    .clk(clk), .rstN(rstN), .irqIn(irqInT), .wrEn(wrEnT), .addr(addrT),
    .wrData(wrDataT), .rdData(rdDataP), .irqOut(irqOutP)
  );

  // bench model, built from the requirements
  logic [7:0] h1, h2, h3, mLatch, mEnable;
  logic       mMaster, mOutLvl, mOutPulse, mActPrev;

  function automatic logic [7:0] levelNow();
    return (irqInT ~^ POL) & ~EDGE;
  endfunction

  function automatic logic [7:0] mStatus();
    return mLatch | levelNow();
  endfunction

  function automatic logic [31:0] mVector();
    logic [7:0] p = mStatus() & mEnable;
    for (int i = 0; i < N; i++) if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] expRead(logic [2:0] a);
    case (a)
      3'd0: return {24'h0, mStatus()};
      3'd1: return {24'h0, mStatus() & mEnable};
      3'd2: return {24'h0, mEnable};
      3'd4: return {31'h0, mMaster};
      3'd5: return mVector();
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(logic [2:0] a);
    case (a)
      3'd0: return "R2/R4";
      3'd1: return "R5";
      3'd2: return "R5/R10";
      3'd3: return "R3";
      3'd4: return "R7/R10";
      3'd5: return "R6";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      h1 <= '0; h2 <= '0; h3 <= '0; mLatch <= '0; mEnable <= '0;
      mMaster <= 1'b0; mOutLvl <= 1'b0; mOutPulse <= 1'b1; mActPrev <= 1'b0;
    end else begin
      logic [7:0] ackB;
      logic       act;
      ackB = (wrEnT && addrT == 3'd3) ? wrDataT[7:0] : 8'h0;
      act  = (|(mStatus() & mEnable)) & mMaster;
      h1 <= irqInT ~^ POL; h2 <= h1; h3 <= h2;
      mLatch <= ((h2 & ~h3) & EDGE) | (mLatch & ~ackB);
      if (wrEnT && addrT == 3'd2) mEnable <= wrDataT[7:0];
      if (wrEnT && addrT == 3'd4) mMaster <= wrDataT[0];
      mOutLvl   <= act;
      mActPrev  <= act;
      mOutPulse <= (act & ~mActPrev) ? 1'b0 : 1'b1;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // wait for the sampling point and compare everything visible
  task automatic step(string tag = "");
    logic [31:0] e;
    @(negedge clk);
    e = expRead(addrT);
    check(rdData === e, (tag != "") ? tag : tagOf(addrT), rdData, e);
    check(irqOutL === mOutLvl, (tag != "") ? tag : "R7", 32'(irqOutL), 32'(mOutLvl));
    check(irqOutP === mOutPulse, (tag != "") ? tag : "R8", 32'(irqOutP), 32'(mOutPulse));
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wrEnT = 1'b1; addrT = a; wrDataT = d;
    step();
    wrEnT = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, string tag = "");
    addrT = a;
    step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      $display("FAIL R7 watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values across the map
    for (int a = 0; a < 8; a++) rd(3'(a), "R1");

    // R7: line pending but master closed
    wr(3'd2, 32'hFF);
    irqInT[4] = 1'b1;            // level active-high line
    repeat (3) rd(3'd1);
    check(irqOutL === 1'b0, "R7", 32'(irqOutL), 32'd0);
    wr(3'd4, 32'h1);
    rd(3'd5);                     // R6: vector 4
    check(rdData === 32'd4, "R6", rdData, 32'd4);

    // R4: ack on level line has no effect
    wr(3'd3, 32'h10);
    rd(3'd0);
    check(rdData[4] === 1'b1, "R4", rdData, 32'h10);
    irqInT[4] = 1'b0;
    rd(3'd0);
    // R9: write to read-only registers ignored
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd5, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, "R9");

    // R2/R6: edges on lines 1 (falling) and 3 (falling)
    irqInT[1] = 1'b0; irqInT[3] = 1'b0;
    repeat (4) rd(3'd5);
    check(rdData === 32'd1, "R6", rdData, 32'd1);
    wr(3'd3, 32'h02);
    rd(3'd5);
    check(rdData === 32'd3, "R6", rdData, 32'd3);
    wr(3'd3, 32'h08);
    rd(3'd5);
    check(rdData === 32'hFFFF_FFFF, "R6", rdData, 32'hFFFF_FFFF);
    irqInT[1] = 1'b1; irqInT[3] = 1'b1;

    // R3: acknowledge colliding with a fresh capture on line 0
    irqInT[0] = 1'b1; repeat (4) rd(3'd0);
    irqInT[0] = 1'b0; repeat (3) rd(3'd0);
    irqInT[0] = 1'b1;
    rd(3'd0); rd(3'd0);
    wr(3'd3, 32'h01);
    rd(3'd0);
    check(rdData[0] === 1'b1, "R3", rdData, 32'h1);
    wr(3'd3, 32'h01);
    rd(3'd0);
    check(rdData[0] === 1'b0, "R3", rdData, 32'h0);
    irqInT[0] = 1'b0;

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      irqInT = irqInT ^ 8'($urandom & $urandom & $urandom);
      addrT = 3'($urandom);
      wrEnT = ($urandom % 3) == 0;
      wrDataT = $urandom;
      if (addrT == 3'd4 && ($urandom % 4) != 0) wrDataT[0] = 1'b1;
      step();
    end
    wrEnT = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule